// File: doc/BRIEF.md
# Compare-with-Constant Branch Execute Unit

This block is the execute stage for a 32-bit conditional branch form that tests one data register against a small immediate. It receives three things: the instruction word, the program counter of that instruction, and a group select from the primary decoder. It drives the address of one read port on a 16-entry data register file and takes the register value back on the same cycle. From these it works out whether the branch is taken and what the next program counter is. For the loop-counter forms it also produces a register write-back.

The instruction word holds these fields: a source register index in bits 11..8, a 4-bit constant in bits 15..12, a 15-bit halfword displacement in bits 30..16, and a secondary opcode in bit 31. The 2-bit group select picks one of four families. Equality is code 0, greater-or-equal is code 1, less-than is code 2, and not-equal-with-update is code 3. Within each family, bit 31 picks the variant. That bit also decides whether the constant is sign-extended or zero-extended. All results are combinational from the inputs. A registered valid follows the input valid by one clock.

Top module: `immBranchExec`

## Requirements
- R1: `rfRdAddr` and `wbAddr` both equal instruction bits 11..8.
- R2: With `inValid` high and the branch not taken, `nextPc` is `pc + 4`. With the branch taken, `nextPc` is `pc` plus the sign-extended bits 30..16 shifted left by one, modulo 2^32.
- R3: Group 0 compares the register with the sign-extended constant. Bit 31 = 0 takes the branch when they are equal. Bit 31 = 1 takes it when they differ.
- R4: In group 1 with bit 31 = 0, the branch is taken when the register, read as signed, is greater than or equal to the sign-extended constant.
- R5: In group 1 with bit 31 = 1, the branch is taken when the register, read as unsigned, is greater than or equal to the zero-extended constant.
- R6: Group 2 takes the branch on less-than. Bit 31 = 0 gives a signed compare against the sign-extended constant. Bit 31 = 1 gives an unsigned compare against the zero-extended constant.
- R7: Group 3 with bit 31 = 0 is the decrement form. It takes the branch when the original register value differs from the sign-extended constant. `wbEn` is high and `wbData` is the register minus one, modulo 2^32, whether or not the branch is taken.
- R8: Group 3 with bit 31 = 1 is the increment form. It takes the branch under the same not-equal test. `wbEn` is high and `wbData` is the register plus one, modulo 2^32, whether or not the branch is taken.
- R9: `wbEn` is high only for group 3 with `inValid` high. When `inValid` is low, `taken` and `wbEn` are both low, whatever the other inputs are.
- R10: `outValid` is low during reset. After reset it equals `inValid` from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Instruction on the inputs is valid |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| group | input | 2 | Family select: 0 equality, 1 greater-or-equal, 2 less-than, 3 not-equal-with-update |
| rfRdAddr | output | 4 | Register file read index |
| rfRdData | input | 32 | Register file read value |
| taken | output | 1 | Branch is taken |
| nextPc | output | 32 | Next program counter |
| wbEn | output | 1 | Register write-back enable |
| wbAddr | output | 4 | Write-back register index |
| wbData | output | 32 | Write-back value |
| outValid | output | 1 | Input valid delayed by one clock |

## Verification
The sweep runs every group, variant and constant against register values that sit on either side of each constant, around zero, and at the signed and unsigned extremes. These are the points where a compare that uses the wrong signedness or the wrong extension flips its result: for example, a zero-extended constant of 0xF used in a signed test would fail to match -1. The increment and decrement forms are driven both at their wrap points and with register values equal to the constant. This exposes a write-back that is dropped on a not-taken branch, and a not-equal test that looks at the updated value instead of the original. Displacements at the most positive and most negative values catch a target that is not sign-extended or not scaled to halfwords. Vectors with `inValid` low confirm that nothing is taken and nothing is written back.

// File: rtl/brcPkg.sv
package brcPkg;
  localparam int XLEN   = 32;
  localparam int REGAW  = 4;
  localparam int CONSTW = 4;
  localparam int DISPW  = 15;

  typedef enum logic [1:0] {
    GRP_EQ    = 2'd0,
    GRP_GE    = 2'd1,
    GRP_LT    = 2'd2,
    GRP_NEUPD = 2'd3
  } grpE;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GE = 2'd2,
    CMP_LT = 2'd3
  } cmpE;

  typedef struct packed {
    cmpE  cmpOp;
    logic signedCmp;
    logic signExtImm;
    logic wbEn;
    logic wbIncr;
    logic live;
  } ctrlS;
endpackage

// File: rtl/immBranchCtrl.sv
module immBranchCtrl
  import brcPkg::*;
(
  input  logic [1:0] group,
  input  logic       subOp,
  input  logic       inValid,
  output ctrlS       strobes
);
  grpE grp;
  assign grp = grpE'(group);

  always_comb begin
    strobes            = '0;
    strobes.live       = inValid;
    strobes.signExtImm = 1'b1;
    strobes.signedCmp  = 1'b1;
    unique case (grp)
      GRP_EQ: begin
        strobes.cmpOp = subOp ? CMP_NE : CMP_EQ;
      end
      GRP_GE: begin
        strobes.cmpOp      = CMP_GE;
        strobes.signedCmp  = !subOp;
        strobes.signExtImm = !subOp;
      end
      GRP_LT: begin
        strobes.cmpOp      = CMP_LT;
        strobes.signedCmp  = !subOp;
        strobes.signExtImm = !subOp;
      end
      default: begin
        strobes.cmpOp  = CMP_NE;
        strobes.wbEn   = inValid;
        strobes.wbIncr = subOp;
      end
    endcase
  end
endmodule

// File: rtl/immBranchDatapath.sv
module immBranchDatapath
  import brcPkg::*;
#(
  parameter int DW        = XLEN,
  parameter int AW        = REGAW,
  parameter int CW        = CONSTW,
  parameter int DSW       = DISPW,
  parameter int INSTBYTES = 4,
  parameter int REGLSB    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DW-1:REGLSB]  instrHi,
  input  logic [DW-1:0]       pc,
  input  logic [DW-1:0]       rfRdData,
  input  ctrlS                strobes,
  output logic [AW-1:0]       regIdx,
  output logic                taken,
  output logic [DW-1:0]       nextPc,
  output logic [DW-1:0]       wbData
);
  localparam int CLSB = REGLSB + AW;
  localparam int DLSB = CLSB + CW;
  localparam int SUBB = DLSB + DSW;

  logic [CW-1:0]  constField;
  logic [DSW-1:0] dispField;
  logic [DW-1:0]  immExt;
  logic [DW-1:0]  dispOff;
  logic           eqHit, ltSigned, ltUnsigned, ltSel, condHit;

  assign regIdx     = instrHi[CLSB-1:REGLSB];
  assign constField = instrHi[DLSB-1:CLSB];
  assign dispField  = instrHi[SUBB-1:DLSB];

  assign immExt  = strobes.signExtImm ? {{(DW-CW){constField[CW-1]}}, constField}
                                      : {{(DW-CW){1'b0}}, constField};
  assign dispOff = {{(DW-DSW-1){dispField[DSW-1]}}, dispField, 1'b0};

  assign eqHit      = (rfRdData == immExt);
  assign ltSigned   = ($signed(rfRdData) < $signed(immExt));
  assign ltUnsigned = (rfRdData < immExt);
  assign ltSel      = strobes.signedCmp ? ltSigned : ltUnsigned;

  always_comb begin
    unique case (strobes.cmpOp)
      CMP_EQ:  condHit = eqHit;
      CMP_NE:  condHit = !eqHit;
      CMP_GE:  condHit = !ltSel;
      default: condHit = ltSel;
    endcase
  end

  assign taken  = strobes.live && condHit;
  assign nextPc = taken ? (pc + dispOff) : (pc + DW'(INSTBYTES));
  assign wbData = strobes.wbIncr ? (rfRdData + 1'b1) : (rfRdData - 1'b1);

  // R4 / R6: for one operand pair, the signed and unsigned orderings can only
  // differ when exactly one sign bit is set
  assert_order_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ltSigned != ltUnsigned) |-> (rfRdData[DW-1] != immExt[DW-1]));

  // R3: equality excludes both less-than results
  assert_eq_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    eqHit |-> (!ltSigned && !ltUnsigned));
endmodule

// File: rtl/immBranchExec.sv
module immBranchExec
  import brcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [XLEN-1:0]  instr,
  input  logic [XLEN-1:0]  pc,
  input  logic [1:0]       group,
  output logic [REGAW-1:0] rfRdAddr,
  input  logic [XLEN-1:0]  rfRdData,
  output logic             taken,
  output logic [XLEN-1:0]  nextPc,
  output logic             wbEn,
  output logic [REGAW-1:0] wbAddr,
  output logic [XLEN-1:0]  wbData,
  output logic             outValid
);
  localparam int SUBBIT = XLEN - 1;

  ctrlS strobes;
  logic unusedOpLow;
  assign unusedOpLow = ^instr[7:0];

  immBranchCtrl i_ctrl (
    .group   (group),
    .subOp   (instr[SUBBIT]),
    .inValid (inValid),
    .strobes (strobes)
  );

  immBranchDatapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .instrHi  (instr[XLEN-1:8]),
    .pc       (pc),
    .rfRdData (rfRdData),
    .strobes  (strobes),
    .regIdx   (rfRdAddr),
    .taken    (taken),
    .nextPc   (nextPc),
    .wbData   (wbData)
  );

  assign wbEn   = strobes.wbEn;
  assign wbAddr = rfRdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_wb_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (inValid && group == 2'd3));
  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !taken) |-> (nextPc == pc + 32'd4));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!taken && !wbEn));
endmodule

// File: tb/test_immBranchExec.sv
`timescale 1ns/1ps
module test_immBranchExec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [1:0]  group = '0;
  logic [3:0]  rfRdAddr;
  logic [31:0] rfRdData = '0;
  logic        taken;
  logic [31:0] nextPc;
  logic        wbEn;
  logic [3:0]  wbAddr;
  logic [31:0] wbData;
  logic        outValid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = !clk;

  immBranchExec i_immBranchExec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .pc(pc),
    .group(group), .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .taken(taken),
    .nextPc(nextPc), .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData),
    .outValid(outValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h grp=%0d instr=%h reg=%h", req, act, exp, group, instr, rfRdData);
    end
  endtask

  task automatic runVec(input logic v, input logic [1:0] g, input logic sub,
                        input logic [14:0] disp, input logic [3:0] k,
                        input logic [3:0] ra, input logic [31:0] rv, input logic [31:0] p);
    logic [31:0] sx, zx, tgt;
    logic expT;
    string tagT;
    @(negedge clk);
    inValid = v; group = g; pc = p; rfRdData = rv;
    instr = {sub, disp, k, ra, 8'h5A};
    sx = {{28{k[3]}}, k};
    zx = {28'd0, k};
    tgt = p + {{16{disp[14]}}, disp, 1'b0};
    case (g)
      2'd0: begin expT = sub ? (rv != sx) : (rv == sx); tagT = "R3"; end
      2'd1: begin
        expT = sub ? (rv >= zx) : ($signed(rv) >= $signed(sx));
        tagT = sub ? "R5" : "R4";
      end
      2'd2: begin expT = sub ? (rv < zx) : ($signed(rv) < $signed(sx)); tagT = "R6"; end
      default: begin expT = (rv != sx); tagT = sub ? "R8" : "R7"; end
    endcase
    if (!v) begin expT = 1'b0; tagT = "R9"; end
    #1;
    check("R1", {28'd0, rfRdAddr}, {28'd0, ra});
    check("R1", {28'd0, wbAddr}, {28'd0, ra});
    check(tagT, {31'd0, taken}, {31'd0, expT});
    if (v) check("R2", nextPc, expT ? tgt : p + 32'd4);
    check("R9", {31'd0, wbEn}, {31'd0, v && g == 2'd3});
    if (v && g == 2'd3) check(sub ? "R8" : "R7", wbData, sub ? rv + 32'd1 : rv - 32'd1);
    @(posedge clk); #1;
    check("R10", {31'd0, outValid}, {31'd0, v});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [0:9];
    logic [14:0] disps [0:4];
    vals[0] = 32'h0;        vals[1] = 32'hFFFF_FFFF; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h7;        vals[5] = 32'h8;
    vals[6] = 32'hFFFF_FFF8; vals[7] = 32'hFFFF_FFF7; vals[8] = 32'hF;
    vals[9] = 32'h10;
    disps[0] = 15'h0; disps[1] = 15'h3FFF; disps[2] = 15'h4000;
    disps[3] = 15'h7FFF; disps[4] = 15'h0123;
    repeat (3) @(posedge clk);
    #1;
    check("R10", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 16; k++) begin
          logic [31:0] kx;
          kx = {{28{k[3]}}, k[3:0]};
          for (int d = -2; d <= 2; d++)
            runVec(1'b1, g[1:0], s[0], disps[(k + d + 2) % 5], k[3:0],
                   4'((k + d) & 15), kx + 32'(d), 32'h1000_0000 + 32'(k * 64));
          runVec(1'b1, g[1:0], s[0], disps[k % 5], k[3:0], 4'(k), {28'd0, k[3:0]}, 32'hFFFF_FFF0);
          for (int i = 0; i < 10; i++)
            runVec(1'b1, g[1:0], s[0], disps[i % 5], k[3:0], 4'(i), vals[i], 32'h0000_2000);
        end
    for (int g = 0; g < 4; g++)
      runVec(1'b0, g[1:0], g[0], 15'h1234, 4'h3, 4'h9, 32'h5, 32'h400);
    runVec(1'b1, 2'd3, 1'b0, 15'h10, 4'h0, 4'h2, 32'h0, 32'h100);
    runVec(1'b1, 2'd3, 1'b1, 15'h10, 4'hF, 4'h2, 32'hFFFF_FFFF, 32'h100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule